// File: doc/BRIEF.md
# Downstream Port Line Forcing and Line-State Monitor

This block sits between hub firmware and the pad drivers of a set of downstream USB ports. Firmware picks a line state for each port with a two-bit code: released, differential one, differential zero, or single-ended zero. A separate pull-low mask drives any single D+ or D− pin low. That mask path bypasses edge-rate shaping and stays active while the hub is suspended, so firmware can hold pins low through suspend. Setting the whole mask puts every port into SE0, which an unconfigured hub needs.

On the receive side, every D+ and D− input passes through a two-flop synchronizer. The block then reports, per port, whether the line is in SE0 and what the last differential value was. While a port sits in SE0 its data bit holds the value it had before SE0 began. Both status words clear on a system reset and on a bus reset.

Firmware reaches the block through a small synchronous register port: an address, a write strobe, write data, and read data that is combinational from the address.

Top module: `hub_dsp_force`

## Requirements
- R1: Port p takes its code from mode register bits [2p+1:2p]. With the pull-low mask clear: code 0 leaves both pins undriven (oe low). Code 1 drives D+ high and D− low. Code 2 drives D+ low and D− high. Code 3 drives both pins low.
- R2: Pull-low mask bit 2p controls D+ of port p and bit 2p+1 controls D− of port p. A set bit drives that pin low with its output enable high, whatever the port's code is.
- R3: A pin's edge-rate output is high exactly when the pin is driven through a nonzero code and its mask bit is clear. A pin held by the mask never has edge-rate control.
- R4: While `suspend` is high, codes have no effect: pins whose mask bit is clear are undriven and have no edge-rate control. Mask-driven pins stay driven low.
- R5: With all mask bits set, every port drives SE0 (all pins low, all enables high) for any code and any suspend state.
- R6: SE0 status bit p (address 2) is 1 when the synchronized D+ and D− of port p are both low. It follows a pad change on the third rising clock edge after the change.
- R7: Data bit p (address 3) is 1 when synchronized D+ is high and D− is low, and 0 for differential zero or SE1. It has the same three-edge latency and no speed setting affects it.
- R8: While synchronized port p is in SE0, its data bit keeps the value it had before SE0 began.
- R9: The SE0 status and data registers read zero after a system reset and one cycle after a cycle with `bus_rst` high. `bus_rst` wins over a line change in the same cycle. Mode and mask registers are untouched by `bus_rst`.
- R10: Address 0 is the mode register and address 1 the pull-low mask, both writable and read back as written. Address 2 is SE0 status and address 3 is data, both read-only. Both writable registers reset to zero.
- R11: Writes to addresses 2 through 7 change nothing. Bits above the used width and addresses 4 through 7 read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| bus_rst | input | 1 | Synchronous bus reset, clears the status words |
| suspend | input | 1 | Hub suspended; disables code-based forcing |
| reg_addr | input | ADDR_W | Register address |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data for reg_addr |
| dp_in | input | NUM_PORTS | D+ pad inputs |
| dm_in | input | NUM_PORTS | D− pad inputs |
| dp_out | output | NUM_PORTS | D+ drive value |
| dp_oe | output | NUM_PORTS | D+ output enable |
| dm_out | output | NUM_PORTS | D− drive value |
| dm_oe | output | NUM_PORTS | D− output enable |
| dp_slew | output | NUM_PORTS | D+ edge-rate control enable |
| dm_slew | output | NUM_PORTS | D− edge-rate control enable |

## Verification
A bus reset can land on the same clock edge at which a new line state reaches the status stage. The bench provokes this on purpose: it drives SE0 on one port and raises `bus_rst` exactly three edges later. The cycle-accurate model expects the clear to win on that edge and the SE0 flag to show up one edge afterward, with the data bit still zero. The second collision is a mask bit and a nonzero code aimed at the same pin. It is exercised in every suspend state and judged at the pad outputs on every cycle.

// File: rtl/hub_dsp_pkg.sv
package hub_dsp_pkg;

  typedef enum logic [1:0] {
    DRV_RELEASE = 2'd0,
    DRV_DIFF1   = 2'd1,
    DRV_DIFF0   = 2'd2,
    DRV_SE0     = 2'd3
  } line_drv_e;

  localparam int unsigned ADDR_MODE = 0;
  localparam int unsigned ADDR_PULL = 1;
  localparam int unsigned ADDR_SE0  = 2;
  localparam int unsigned ADDR_DIFF = 3;

endpackage

// File: rtl/hub_dsp_regs.sv
module hub_dsp_regs
  import hub_dsp_pkg::*;
#(
  parameter int unsigned NUM_PORTS = 4,
  parameter int unsigned ADDR_W    = 3,
  parameter int unsigned DATA_W    = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [ADDR_W-1:0]      addr,
  input  logic [DATA_W-1:0]      wdata,
  input  logic [NUM_PORTS-1:0]   se0_stat,
  input  logic [NUM_PORTS-1:0]   diff_stat,
  output logic [2*NUM_PORTS-1:0] mode_q,
  output logic [2*NUM_PORTS-1:0] pull_q,
  output logic [DATA_W-1:0]      rdata
);
  localparam int unsigned PIN_W = 2 * NUM_PORTS;

  logic              mode_we;
  logic              pull_we;
  logic [PIN_W-1:0]  mode_d;
  logic [PIN_W-1:0]  pull_d;

  // R10 R11: only the two writable addresses accept a write
  always_comb begin
    mode_we = wr_en && (addr == ADDR_W'(ADDR_MODE));
    pull_we = wr_en && (addr == ADDR_W'(ADDR_PULL));
    mode_d  = wdata[PIN_W-1:0];
    pull_d  = wdata[PIN_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      pull_q <= '0;
    end else begin
      if (mode_we) mode_q <= mode_d;
      if (pull_we) pull_q <= pull_d;
    end
  end

  // R11: upper bits and unused addresses read as zero
  always_comb begin
    unique case (addr)
      ADDR_W'(ADDR_MODE): rdata = DATA_W'(mode_q);
      ADDR_W'(ADDR_PULL): rdata = DATA_W'(pull_q);
      ADDR_W'(ADDR_SE0):  rdata = DATA_W'(se0_stat);
      ADDR_W'(ADDR_DIFF): rdata = DATA_W'(diff_stat);
      default:            rdata = '0;
    endcase
  end

endmodule

// File: rtl/hub_dsp_drive.sv
module hub_dsp_drive
  import hub_dsp_pkg::*;
#(
  parameter int unsigned NUM_PORTS = 4
) (
  input  logic [2*NUM_PORTS-1:0] mode_q,
  input  logic [2*NUM_PORTS-1:0] pull_q,
  input  logic                   suspend,
  output logic [NUM_PORTS-1:0]   dp_out,
  output logic [NUM_PORTS-1:0]   dp_oe,
  output logic [NUM_PORTS-1:0]   dm_out,
  output logic [NUM_PORTS-1:0]   dm_oe,
  output logic [NUM_PORTS-1:0]   dp_slew,
  output logic [NUM_PORTS-1:0]   dm_slew
);

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    line_drv_e code_eff;
    logic      code_act;
    logic      code_dp;
    logic      code_dm;
    logic      pull_dp;
    logic      pull_dm;

    always_comb begin
      // R4: suspend drops code forcing, mask stays active
      code_eff = suspend ? DRV_RELEASE : line_drv_e'(mode_q[2*p +: 2]);
      code_act = (code_eff != DRV_RELEASE);
      code_dp  = (code_eff == DRV_DIFF1);
      code_dm  = (code_eff == DRV_DIFF0);
      pull_dp  = pull_q[2*p];
      pull_dm  = pull_q[2*p+1];
      // R1 R2: mask drive overrides the code on its pin
      dp_oe[p]   = pull_dp | code_act;
      dm_oe[p]   = pull_dm | code_act;
      dp_out[p]  = !pull_dp && code_dp;
      dm_out[p]  = !pull_dm && code_dm;
      // R3: edge-rate shaping only for code-driven pins
      dp_slew[p] = !pull_dp && code_act;
      dm_slew[p] = !pull_dm && code_act;
    end
  end

endmodule

// File: rtl/hub_dsp_monitor.sv
module hub_dsp_monitor #(
  parameter int unsigned NUM_PORTS   = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_rst,
  input  logic [NUM_PORTS-1:0] dp_in,
  input  logic [NUM_PORTS-1:0] dm_in,
  output logic [NUM_PORTS-1:0] dp_sync,
  output logic [NUM_PORTS-1:0] dm_sync,
  output logic [NUM_PORTS-1:0] se0_q,
  output logic [NUM_PORTS-1:0] diff_q
);
  localparam int unsigned LAST = SYNC_STAGES - 1;

  logic [NUM_PORTS-1:0] dp_pipe_q [SYNC_STAGES];
  logic [NUM_PORTS-1:0] dm_pipe_q [SYNC_STAGES];
  logic [NUM_PORTS-1:0] line_se0;
  logic [NUM_PORTS-1:0] se0_d;
  logic [NUM_PORTS-1:0] diff_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SYNC_STAGES; s++) begin
        dp_pipe_q[s] <= '0;
        dm_pipe_q[s] <= '0;
      end
    end else begin
      dp_pipe_q[0] <= dp_in;
      dm_pipe_q[0] <= dm_in;
      for (int s = 1; s < SYNC_STAGES; s++) begin
        dp_pipe_q[s] <= dp_pipe_q[s-1];
        dm_pipe_q[s] <= dm_pipe_q[s-1];
      end
    end
  end

  assign dp_sync = dp_pipe_q[LAST];
  assign dm_sync = dm_pipe_q[LAST];

  // R6 R7 R8 R9: next state of the status words
  always_comb begin
    line_se0 = ~dp_sync & ~dm_sync;
    if (bus_rst) begin
      se0_d  = '0;
      diff_d = '0;
    end else begin
      se0_d  = line_se0;
      diff_d = (diff_q & line_se0) | (dp_sync & ~dm_sync);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      se0_q  <= '0;
      diff_q <= '0;
    end else begin
      se0_q  <= se0_d;
      diff_q <= diff_d;
    end
  end

endmodule

// File: rtl/hub_dsp_force.sv
module hub_dsp_force #(
  parameter int unsigned NUM_PORTS = 4,
  parameter int unsigned ADDR_W    = 3,
  parameter int unsigned DATA_W    = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_rst,
  input  logic                 suspend,
  input  logic [ADDR_W-1:0]    reg_addr,
  input  logic                 reg_wr,
  input  logic [DATA_W-1:0]    reg_wdata,
  output logic [DATA_W-1:0]    reg_rdata,
  input  logic [NUM_PORTS-1:0] dp_in,
  input  logic [NUM_PORTS-1:0] dm_in,
  output logic [NUM_PORTS-1:0] dp_out,
  output logic [NUM_PORTS-1:0] dp_oe,
  output logic [NUM_PORTS-1:0] dm_out,
  output logic [NUM_PORTS-1:0] dm_oe,
  output logic [NUM_PORTS-1:0] dp_slew,
  output logic [NUM_PORTS-1:0] dm_slew
);
  localparam int unsigned PIN_W = 2 * NUM_PORTS;

  logic              rst_meta_q;
  logic              rst_sync_n;
  logic [PIN_W-1:0]  mode_q;
  logic [PIN_W-1:0]  pull_q;
  logic [NUM_PORTS-1:0] dp_sync;
  logic [NUM_PORTS-1:0] dm_sync;
  logic [NUM_PORTS-1:0] se0_q;
  logic [NUM_PORTS-1:0] diff_q;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  hub_dsp_regs #(
    .NUM_PORTS(NUM_PORTS),
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W)
  ) u_regs (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .wr_en    (reg_wr),
    .addr     (reg_addr),
    .wdata    (reg_wdata),
    .se0_stat (se0_q),
    .diff_stat(diff_q),
    .mode_q   (mode_q),
    .pull_q   (pull_q),
    .rdata    (reg_rdata)
  );

  hub_dsp_drive #(
    .NUM_PORTS(NUM_PORTS)
  ) u_drive (
    .mode_q (mode_q),
    .pull_q (pull_q),
    .suspend(suspend),
    .dp_out (dp_out),
    .dp_oe  (dp_oe),
    .dm_out (dm_out),
    .dm_oe  (dm_oe),
    .dp_slew(dp_slew),
    .dm_slew(dm_slew)
  );

  hub_dsp_monitor #(
    .NUM_PORTS  (NUM_PORTS),
    .SYNC_STAGES(2)
  ) u_mon (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .bus_rst(bus_rst),
    .dp_in  (dp_in),
    .dm_in  (dm_in),
    .dp_sync(dp_sync),
    .dm_sync(dm_sync),
    .se0_q  (se0_q),
    .diff_q (diff_q)
  );

endmodule

// File: rtl/hub_dsp_force_chk.sv
module hub_dsp_force_chk #(
  parameter int unsigned NUM_PORTS = 4
) (
  input logic                   clk,
  input logic                   rst_sync_n,
  input logic                   bus_rst,
  input logic                   suspend,
  input logic [2*NUM_PORTS-1:0] mode_q,
  input logic [2*NUM_PORTS-1:0] pull_q,
  input logic [NUM_PORTS-1:0]   dp_sync,
  input logic [NUM_PORTS-1:0]   dm_sync,
  input logic [NUM_PORTS-1:0]   se0_q,
  input logic [NUM_PORTS-1:0]   diff_q,
  input logic [NUM_PORTS-1:0]   dp_out,
  input logic [NUM_PORTS-1:0]   dp_oe,
  input logic [NUM_PORTS-1:0]   dm_out,
  input logic [NUM_PORTS-1:0]   dm_oe,
  input logic [NUM_PORTS-1:0]   dp_slew,
  input logic [NUM_PORTS-1:0]   dm_slew
);

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_chk
    p_pull_dp_low_r2: assert property (@(posedge clk) disable iff (!rst_sync_n)
      pull_q[2*p] |-> (dp_oe[p] && !dp_out[p]));
    p_pull_dm_low_r2: assert property (@(posedge clk) disable iff (!rst_sync_n)
      pull_q[2*p+1] |-> (dm_oe[p] && !dm_out[p]));
    p_pull_no_slew_r3: assert property (@(posedge clk) disable iff (!rst_sync_n)
      (pull_q[2*p] || pull_q[2*p+1]) |->
        !((pull_q[2*p] && dp_slew[p]) || (pull_q[2*p+1] && dm_slew[p])));
    p_code_slew_r3: assert property (@(posedge clk) disable iff (!rst_sync_n)
      (!suspend && (mode_q[2*p +: 2] != 2'b00) && !pull_q[2*p]) |-> dp_slew[p]);
    p_suspend_release_r4: assert property (@(posedge clk) disable iff (!rst_sync_n)
      (suspend && !pull_q[2*p]) |-> (!dp_oe[p] && !dp_slew[p]));
    p_se0_flag_r6: assert property (@(posedge clk) disable iff (!rst_sync_n)
      (!dp_sync[p] && !dm_sync[p] && !bus_rst) |=> se0_q[p]);
    p_se0_hold_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
      (!dp_sync[p] && !dm_sync[p] && !bus_rst) |=> $stable(diff_q[p]));
  end

  p_busrst_clear_r9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    bus_rst |=> ((se0_q == '0) && (diff_q == '0)));

endmodule

bind hub_dsp_force hub_dsp_force_chk #(
  .NUM_PORTS(NUM_PORTS)
) u_chk (
  .clk       (clk),
  .rst_sync_n(rst_sync_n),
  .bus_rst   (bus_rst),
  .suspend   (suspend),
  .mode_q    (mode_q),
  .pull_q    (pull_q),
  .dp_sync   (dp_sync),
  .dm_sync   (dm_sync),
  .se0_q     (se0_q),
  .diff_q    (diff_q),
  .dp_out    (dp_out),
  .dp_oe     (dp_oe),
  .dm_out    (dm_out),
  .dm_oe     (dm_oe),
  .dp_slew   (dp_slew),
  .dm_slew   (dm_slew)
);

// File: tb/hub_dsp_force_bench.sv
`timescale 1ns/1ps
module hub_dsp_force_bench;
  localparam int N      = 4;
  localparam int PIN_W  = 2 * N;
  localparam int ADDR_W = 3;
  localparam int DATA_W = 8;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              bus_rst;
  logic              suspend;
  logic [ADDR_W-1:0] reg_addr;
  logic              reg_wr;
  logic [DATA_W-1:0] reg_wdata;
  logic [DATA_W-1:0] reg_rdata;
  logic [N-1:0]      dp_in, dm_in;
  logic [N-1:0]      dp_out, dp_oe, dm_out, dm_oe, dp_slew, dm_slew;

  int checks = 0;
  int errors = 0;
  bit checking = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  hub_dsp_force #(.NUM_PORTS(N), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_hub_dsp_force (
    .clk(clk), .rst_n(rst_n), .bus_rst(bus_rst), .suspend(suspend),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .dp_in(dp_in), .dm_in(dm_in), .dp_out(dp_out), .dp_oe(dp_oe),
    .dm_out(dm_out), .dm_oe(dm_oe), .dp_slew(dp_slew), .dm_slew(dm_slew)
  );

  // behavioural reference model
  int          m_mode [N];
  bit          m_pull_dp [N], m_pull_dm [N];
  bit          m_se0 [N], m_diff [N];
  bit          m_hist_dp [$], m_hist_dm [$];
  int          m_hold;
  bit          m_sdp [N], m_sdm [N];
  bit          m_s1dp [N], m_s1dm [N];

  task automatic model_clear();
    for (int p = 0; p < N; p++) begin
      m_se0[p] = 0; m_diff[p] = 0;
      m_sdp[p] = 0; m_sdm[p] = 0; m_s1dp[p] = 0; m_s1dm[p] = 0;
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      model_clear();
      for (int p = 0; p < N; p++) begin
        m_mode[p] = 0; m_pull_dp[p] = 0; m_pull_dm[p] = 0;
      end
      m_hold = 2;
    end else if (m_hold > 0) begin
      m_hold = m_hold - 1;
    end else begin
      for (int p = 0; p < N; p++) begin
        if (bus_rst) begin
          m_se0[p] = 0; m_diff[p] = 0;
        end else if (!m_sdp[p] && !m_sdm[p]) begin
          m_se0[p] = 1;
        end else begin
          m_se0[p] = 0;
          m_diff[p] = m_sdp[p] && !m_sdm[p];
        end
        m_sdp[p] = m_s1dp[p]; m_sdm[p] = m_s1dm[p];
        m_s1dp[p] = dp_in[p]; m_s1dm[p] = dm_in[p];
      end
      if (reg_wr) begin
        for (int p = 0; p < N; p++) begin
          if (reg_addr == 0) m_mode[p] = reg_wdata[2*p] + 2 * reg_wdata[2*p+1];
          if (reg_addr == 1) begin
            m_pull_dp[p] = reg_wdata[2*p];
            m_pull_dm[p] = reg_wdata[2*p+1];
          end
        end
      end
    end
  end

  function automatic int expected_rdata(int a);
    int v = 0;
    for (int p = 0; p < N; p++) begin
      case (a)
        0: v += m_mode[p] << (2*p);
        1: v += (m_pull_dp[p] << (2*p)) + (m_pull_dm[p] << (2*p+1));
        2: v += m_se0[p] << p;
        3: v += m_diff[p] << p;
        default: ;
      endcase
    end
    return v;
  endfunction

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    int e_dpo = 0, e_dpe = 0, e_dmo = 0, e_dme = 0, e_dps = 0, e_dms = 0;
    int er;
    string rtag;
    if (!checking) return;
    for (int p = 0; p < N; p++) begin
      int c;
      c = suspend ? 0 : m_mode[p];
      if (m_pull_dp[p]) e_dpe |= 1 << p;
      else if (c != 0) begin
        e_dpe |= 1 << p; e_dps |= 1 << p;
        if (c == 1) e_dpo |= 1 << p;
      end
      if (m_pull_dm[p]) e_dme |= 1 << p;
      else if (c != 0) begin
        e_dme |= 1 << p; e_dms |= 1 << p;
        if (c == 2) e_dmo |= 1 << p;
      end
    end
    check(int'(dp_out) == e_dpo, "R1 R2 R4 dp_out", int'(dp_out), e_dpo);
    check(int'(dp_oe)  == e_dpe, "R1 R2 R4 dp_oe",  int'(dp_oe),  e_dpe);
    check(int'(dm_out) == e_dmo, "R1 R2 R4 dm_out", int'(dm_out), e_dmo);
    check(int'(dm_oe)  == e_dme, "R1 R2 R4 dm_oe",  int'(dm_oe),  e_dme);
    check(int'(dp_slew) == e_dps, "R3 dp_slew", int'(dp_slew), e_dps);
    check(int'(dm_slew) == e_dms, "R3 dm_slew", int'(dm_slew), e_dms);
    er = expected_rdata(int'(reg_addr));
    case (reg_addr)
      0, 1: rtag = "R10 readback";
      2: rtag = "R6 R9 se0 status";
      3: rtag = "R7 R8 R9 data";
      default: rtag = "R11 unused address";
    endcase
    check(int'(reg_rdata) == er, rtag, int'(reg_rdata), er);
  endtask

  task automatic cyc();
    @(negedge clk);
    compare_all();
  endtask

  task automatic wr(int a, int d);
    reg_addr = ADDR_W'(a); reg_wdata = DATA_W'(d); reg_wr = 1;
    cyc();
    reg_wr = 0;
  endtask

  task automatic rd(int a);
    reg_addr = ADDR_W'(a);
    #0.1;
    compare_all();
  endtask

  initial begin
    rst_n = 0; bus_rst = 0; suspend = 0; reg_addr = '0; reg_wr = 0; reg_wdata = '0;
    dp_in = '1; dm_in = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (2) @(negedge clk);
    checking = 1;
    // reset state, R10 R11
    for (int a = 0; a < 8; a++) begin
      rd(a);
      check(reg_rdata == '0, "R10 reset readback", int'(reg_rdata), 0);
    end
    // R1: one code per port
    wr(0, 8'b11_10_01_00);
    repeat (2) cyc();
    check(dp_out == 4'b0010 && dm_out == 4'b0100 && dp_oe == 4'b1110,
          "R1 code decode", int'({dp_out, dm_out}), 8'h24);
    // R2 R3: mask overlapping codes
    wr(1, 8'b01_10_01_10);
    repeat (2) cyc();
    suspend = 1;  // R4
    repeat (3) cyc();
    wr(0, 8'hFF);
    suspend = 0;
    repeat (2) cyc();
    // R5: full mask
    wr(1, 8'hFF);
    cyc();
    for (int s = 0; s < 2; s++) begin
      suspend = s[0];
      #0.1;
      check(dp_out == '0 && dm_out == '0 && dp_oe == '1 && dm_oe == '1,
            "R5 all ports SE0", int'({dp_out, dm_out, dp_oe, dm_oe}), 16'h00FF);
      cyc();
    end
    suspend = 0;
    wr(1, 0);
    // R6 R7 R8: line patterns
    dp_in = 4'b0101; dm_in = 4'b1010;
    for (int a = 0; a < 5; a++) begin reg_addr = ADDR_W'(2 + a[0]); cyc(); end
    dp_in = 4'b0100; dm_in = 4'b0000;   // SE0 on 0,1,3
    for (int a = 0; a < 6; a++) begin reg_addr = ADDR_W'(2 + a[0]); cyc(); end
    rd(3);
    check(reg_rdata == 8'h05, "R8 hold during SE0", int'(reg_rdata), 5);
    dp_in = 4'b1111; dm_in = 4'b1111;   // SE1 -> data 0
    for (int a = 0; a < 5; a++) begin reg_addr = ADDR_W'(3); cyc(); end
    // R9: bus reset collides with SE0 reaching status
    dp_in = 4'b1111; dm_in = 4'b0000;
    repeat (4) cyc();
    dp_in[1] = 0;
    reg_addr = 2;
    cyc(); cyc();
    bus_rst = 1;
    cyc();
    bus_rst = 0;
    rd(2);
    check(reg_rdata == '0, "R9 bus reset wins", int'(reg_rdata), 0);
    cyc();
    check(reg_rdata == 8'h02, "R6 SE0 after bus reset", int'(reg_rdata), 2);
    // R11: writes to read-only / unused addresses
    for (int a = 2; a < 8; a++) wr(a, 8'hFF);
    rd(2); rd(3); rd(5);
    check(reg_rdata == '0, "R11 unused read zero", int'(reg_rdata), 0);
    // mixed random traffic
    for (int i = 0; i < 800; i++) begin
      if ($urandom_range(3) == 0) begin dp_in = N'($urandom); dm_in = N'($urandom); end
      bus_rst = ($urandom_range(31) == 0);
      if ($urandom_range(31) == 0) suspend = ~suspend;
      reg_wr = ($urandom_range(7) == 0);
      reg_addr = ADDR_W'($urandom);
      reg_wdata = DATA_W'($urandom);
      if (i == 400) rst_n = 0;
      if (i == 401) rst_n = 1;
      cyc();
    end
    reg_wr = 0; bus_rst = 0;
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired, actual=running expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule